// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register side of a serial port. A processor reaches it through a simple single-cycle bus: one access per valid cycle, with a 32-bit word-aligned address inside a 1 KiB window. Behind that bus sit seven words:

- a status word holding the receive-full, transfer-complete and transmit-empty flags;
- a data word;
- five configuration words (baud divisor, three control words and a guard word).

Only the first control word affects behaviour. The other four configuration words are plain storage.

Received bytes come in on a valid/ready byte stream. Transmitted bytes go out as a one-cycle valid pulse with the byte, and the sink always takes them. Transmission is modelled as finishing at once. Because of that, transmit-empty stays set and transfer-complete is raised again on every accepted data write.

One registered, level-sensitive interrupt line is high when any enabled flag is set. Reads return data registered one clock after the access.

Top module: `serial_port_regs`

## Requirements
- R1: After synchronous reset, the status word (offset 0x00) reads 0x0000_00C0 and every other mapped word reads 0. The interrupt and the transmit valid are low, and receive ready is high.
- R2: `irq` is high one clock after any cycle in which status AND control-1 (offset 0x0C) has bit 5 (receive full), bit 6 (transfer complete) or bit 7 (transmit empty) set, and low otherwise.
- R3: `rx_ready` is high exactly while status bit 5 is clear. A byte is taken only in a cycle with `rx_valid` and `rx_ready` both high.
- R4: A taken byte is stored in the data word (offset 0x04) and sets status bit 5 only when control-1 bits 13 (port enable) and 2 (receiver enable) are both 1. Otherwise it is discarded, and the data word and bit 5 are unchanged.
- R5: A read of the data word returns its low 10 bits and clears status bit 5.
- R6: A status write with a value of 0x3FF or less replaces the status word with that value, with bit 7 forced to 1.
- R7: A status write with a value above 0x3FF ANDs the value into the status word.
- R8: A data write with a value below 0xF000 emits the low byte on `tx_byte` with `tx_valid` high for one cycle, starting the clock after the write, and sets status bit 6. A data write of 0xF000 or more emits nothing and changes no state.
- R9: The words at 0x08, 0x0C, 0x10, 0x14 and 0x18 store all 32 written bits and read them back unchanged.
- R10: Reads of offsets 0x1C to 0x3FC return 0, and writes there change nothing. Address bits 1:0 are ignored. `bus_rdata` is 0 in cycles with no read.
- R11: Read data appears on `bus_rdata` one clock after the read. It shows the word as it was before any update made at that same edge.
- R12: When several events meet in one cycle, they apply in this order: the status write, then the receive-full clear from a data read, then the receive-full set from a stored byte, then the transfer-complete set from a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the read |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte can be taken |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt, registered |

## Verification
Receive traffic is tried three ways, and each separates a different fault:
- with the port disabled or only half enabled, which catches a drop rule that checks only one enable bit;
- with a held valid while the receive-full flag is set, which catches a handshake that ignores back-pressure;
- in the same cycle as a data read or a status write, which exposes the update order.

Status writes straddle the 0x3FF threshold, so replace and AND modes are told apart. Data writes straddle 0xF000, so a wrong comparison bound is caught. A random mix of mapped, unmapped and misaligned accesses, run alongside the receive stream, compares every output on every clock against a behavioural model.

// File: rtl/sp_regs_pkg.sv
package sp_regs_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int WIN_ADDR_W = 10;
  localparam int N_CFG = 5;

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_BAUD  = 3'd2,
    SEL_CTL1  = 3'd3,
    SEL_CTL2  = 3'd4,
    SEL_CTL3  = 3'd5,
    SEL_GUARD = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  localparam int BIT_RXFULL = 5;
  localparam int BIT_TXDONE = 6;
  localparam int BIT_TXEMPT = 7;
  localparam int BIT_RXEN   = 2;
  localparam int BIT_PORTEN = 13;

  localparam logic [DATA_W-1:0] STAT_RST     = 32'h0000_00C0;
  localparam logic [DATA_W-1:0] IRQ_MASK     = 32'h0000_00E0;
  localparam logic [DATA_W-1:0] STAT_SET_MAX = 32'h0000_03FF;
  localparam logic [DATA_W-1:0] TX_LIMIT     = 32'h0000_F000;
  localparam logic [DATA_W-1:0] RD_DATA_MSK  = 32'h0000_03FF;
  localparam int CTL1_IDX = 1;
endpackage

// File: rtl/sp_addr_decode.sv
module sp_addr_decode
  import sp_regs_pkg::*;
#(
  parameter int ADDR_W = WIN_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int N_MAPPED = 7;

  logic [IDX_W-1:0] word_idx;
  assign word_idx = addr[ADDR_W-1:2];

  always_comb begin
    if (word_idx < IDX_W'(N_MAPPED)) sel = reg_sel_e'(word_idx[2:0]);
    else                             sel = SEL_NONE;
  end
endmodule

// File: rtl/sp_cfg_bank.sv
module sp_cfg_bank #(
  parameter int NREG = 5,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREG-1:0]          wr_en,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)           regs[g] <= '0;
      else if (wr_en[g]) regs[g] <= wdata;
    end

    // R9: a word not written keeps its value
    a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
      !wr_en[g] |=> $stable(regs[g]));
    // R9: a written word takes the full write value
    a_r9_take_word: assert property (@(posedge clk) disable iff (rst)
      wr_en[g] |=> regs[g] == $past(wdata));
  end
endmodule

// File: rtl/sp_status_core.sv
module sp_status_core
  import sp_regs_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ctl1,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_byte,
  output logic          rx_ready,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] data_q,
  output logic          tx_valid,
  output logic [BW-1:0] tx_byte
);
  logic stat_wr, data_rd, data_wr, tx_go, rx_fire, rx_keep, rx_on;
  logic [DW-1:0] stat_n, data_n;

  assign stat_wr  = bus_valid &&  bus_we && (sel == SEL_STAT);
  assign data_rd  = bus_valid && !bus_we && (sel == SEL_DATA);
  assign data_wr  = bus_valid &&  bus_we && (sel == SEL_DATA);
  assign tx_go    = data_wr && (wdata < TX_LIMIT);
  assign rx_ready = !stat_q[BIT_RXFULL];
  assign rx_fire  = rx_valid && rx_ready;
  assign rx_on    = ctl1[BIT_PORTEN] && ctl1[BIT_RXEN];
  assign rx_keep  = rx_fire && rx_on;

  always_comb begin
    stat_n = stat_q;
    if (stat_wr) begin
      if (wdata <= STAT_SET_MAX) begin
        stat_n = wdata;
        stat_n[BIT_TXEMPT] = 1'b1;
      end else begin
        stat_n = stat_q & wdata;
      end
    end
    if (data_rd) stat_n[BIT_RXFULL] = 1'b0;
    if (rx_keep) stat_n[BIT_RXFULL] = 1'b1;
    if (tx_go)   stat_n[BIT_TXDONE] = 1'b1;
  end

  always_comb begin
    data_n = data_q;
    if (rx_keep) data_n = DW'(rx_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= STAT_RST;
      data_q   <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      stat_q   <= stat_n;
      data_q   <= data_n;
      tx_valid <= tx_go;
      if (tx_go) tx_byte <= wdata[BW-1:0];
    end
  end

  // R4: stored byte lands in the data word and raises receive-full
  a_r4_store: assert property (@(posedge clk) disable iff (rst)
    rx_keep |=> stat_q[BIT_RXFULL] && (data_q[BW-1:0] == $past(rx_byte)));
  // R4: a byte taken while disabled leaves the data word alone
  a_r4_drop: assert property (@(posedge clk) disable iff (rst)
    rx_fire && !rx_on |=> $stable(data_q));
  // R3: no byte is taken while receive-full is set
  a_r3_blocked: assert property (@(posedge clk) disable iff (rst)
    stat_q[BIT_RXFULL] && !data_rd && !stat_wr |=> $stable(data_q));
  // R5: a data read with receive-full set clears it
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    data_rd && stat_q[BIT_RXFULL] |=> !stat_q[BIT_RXFULL]);
  // R6: small status write keeps transmit-empty set
  a_r6_txe_forced: assert property (@(posedge clk) disable iff (rst)
    stat_wr && (wdata <= STAT_SET_MAX) |=> stat_q[BIT_TXEMPT]);
  // R7: AND-mode status write never sets a bit that was clear
  a_r7_and_only: assert property (@(posedge clk) disable iff (rst)
    stat_wr && (wdata > STAT_SET_MAX) && !rx_keep && !tx_go
    |=> (stat_q & ~$past(stat_q)) == '0);
  // R8: accepted data write pulses the transmit stream and sets complete
  a_r8_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_go |=> tx_valid && stat_q[BIT_TXDONE]);
  // R8: large data write emits nothing
  a_r8_tx_ignored: assert property (@(posedge clk) disable iff (rst)
    data_wr && !tx_go |=> !tx_valid);
endmodule

// File: rtl/sp_irq_gen.sv
module sp_irq_gen
  import sp_regs_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] ctl1,
  output logic          irq
);
  logic [DW-1:0] active;
  assign active = stat & ctl1 & IRQ_MASK;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |active;
  end

  // R2: with all interrupt enables off, the line stays low next cycle
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    ((ctl1 & IRQ_MASK) == '0) |=> !irq);
  // R2: enabled transmit-empty flag raises the line next cycle
  a_r2_txe_raise: assert property (@(posedge clk) disable iff (rst)
    stat[BIT_TXEMPT] && ctl1[BIT_TXEMPT] |=> irq);
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sp_regs_pkg::*;
#(
  parameter int ADDR_W = WIN_ADDR_W,
  parameter int DW     = DATA_W,
  parameter int BW     = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_valid,
  input  logic [BW-1:0]     rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BW-1:0]     tx_byte,
  output logic              irq
);
  localparam int CFG_BASE = int'(SEL_BAUD);

  reg_sel_e                 sel;
  logic [N_CFG-1:0]         cfg_wr;
  logic [N_CFG-1:0][DW-1:0] cfg_q;
  logic [DW-1:0]            stat_q, data_q, ctl1, rd_val;
  logic                     rd_now;

  sp_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_comb begin
    for (int i = 0; i < N_CFG; i++)
      cfg_wr[i] = bus_valid && bus_we && (int'(sel) == CFG_BASE + i);
  end

  sp_cfg_bank #(.NREG(N_CFG), .DW(DW)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr),
    .wdata (bus_wdata),
    .regs  (cfg_q)
  );

  assign ctl1 = cfg_q[CTL1_IDX];

  sp_status_core #(.DW(DW), .BW(BW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .sel       (sel),
    .wdata     (bus_wdata),
    .ctl1      (ctl1),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .stat_q    (stat_q),
    .data_q    (data_q),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  sp_irq_gen #(.DW(DW)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .stat (stat_q),
    .ctl1 (ctl1),
    .irq  (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_val = stat_q;
      SEL_DATA: rd_val = data_q & RD_DATA_MSK;
      SEL_NONE: rd_val = '0;
      default:  rd_val = cfg_q[int'(sel) - CFG_BASE];
    endcase
  end

  assign rd_now = bus_valid && !bus_we;

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_now) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    rd_now && (sel == SEL_NONE) |=> bus_rdata == '0);
  // R10: idle cycles leave read data at zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_now |=> bus_rdata == '0);
  // R11: control-1 read shows the value held at the read edge
  a_r11_read_timing: assert property (@(posedge clk) disable iff (rst)
    rd_now && (sel == SEL_CTL1) |=> bus_rdata == $past(ctl1));
endmodule

// File: tb/sim_serial_port_regs.sv
`timescale 1ns/1ps
module sim_serial_port_regs;
  localparam time TCK = 4ns;
  localparam int  MAX_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_byte;

  always #(TCK/2) clk = ~clk;

  serial_port_regs u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_sr, m_dr;
  logic [31:0] m_cfg [5];
  logic [31:0] e_rdata;
  logic        e_irq, e_txv;
  logic [7:0]  e_txb;
  bit          started = 0;
  int          n_vec = 0, n_bad = 0;
  string       cur_req = "R1";
  bit          done = 0;

  always @(posedge clk) begin
    int w;
    logic [31:0] nsr, rv;
    logic rd, keep, go;
    started = 1;
    if (rst) begin
      m_sr = 32'hC0; m_dr = 0;
      foreach (m_cfg[k]) m_cfg[k] = 0;
      e_rdata = 0; e_irq = 0; e_txv = 0; e_txb = 0;
    end else begin
      w = int'(bus_addr >> 2);
      e_irq = |(m_sr & m_cfg[1] & 32'hE0);
      rd = bus_valid && !bus_we;
      case (w)
        0: rv = m_sr;
        1: rv = m_dr & 32'h3FF;
        2, 3, 4, 5, 6: rv = m_cfg[w-2];
        default: rv = 0;
      endcase
      e_rdata = rd ? rv : 0;
      keep = rx_valid && !m_sr[5] && m_cfg[1][13] && m_cfg[1][2];
      nsr = m_sr;
      if (bus_valid && bus_we && w == 0)
        nsr = (bus_wdata <= 32'h3FF) ? (bus_wdata | 32'h80) : (m_sr & bus_wdata);
      if (rd && w == 1) nsr[5] = 0;
      if (keep) begin nsr[5] = 1; m_dr = {24'h0, rx_byte}; end
      go = bus_valid && bus_we && w == 1 && bus_wdata < 32'hF000;
      e_txv = go;
      if (go) begin e_txb = bus_wdata[7:0]; nsr[6] = 1; end
      if (bus_valid && bus_we && w >= 2 && w <= 6) m_cfg[w-2] = bus_wdata;
      m_sr = nsr;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_vec++;
      if (bus_rdata !== e_rdata) begin
        n_bad++; $display("FAIL %s rdata actual=%h expected=%h", cur_req, bus_rdata, e_rdata);
      end
      if (irq !== e_irq) begin
        n_bad++; $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, e_irq);
      end
      if (tx_valid !== e_txv) begin
        n_bad++; $display("FAIL %s tx_valid actual=%b expected=%b", cur_req, tx_valid, e_txv);
      end
      if (tx_byte !== e_txb) begin
        n_bad++; $display("FAIL %s tx_byte actual=%h expected=%h", cur_req, tx_byte, e_txb);
      end
      if (rx_ready !== !m_sr[5]) begin
        n_bad++; $display("FAIL %s rx_ready actual=%b expected=%b", cur_req, rx_ready, !m_sr[5]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] a);
    @(negedge clk); bus_valid = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic rx(input logic [7:0] b, input int hold);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    repeat (hold) @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] EN_RX = (32'h1 << 13) | (32'h1 << 2);

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd(10'(a * 4));
    // R9: configuration storage
    cur_req = "R9";
    wr(10'h08, 32'hDEAD_BEEF); wr(10'h10, 32'h1234_5678);
    wr(10'h14, 32'hFFFF_FFFF); wr(10'h18, 32'h8000_0001);
    wr(10'h0C, 32'hA5A5_0000);
    for (int a = 2; a < 7; a++) rd(10'(a * 4));
    // R4: port disabled, byte dropped
    cur_req = "R4";
    wr(10'h0C, 32'h0); rx(8'h3C, 1); rd(10'h04); rd(10'h00);
    wr(10'h0C, 32'h1 << 13); rx(8'h3D, 1); rd(10'h04);
    wr(10'h0C, 32'h1 << 2);  rx(8'h3E, 1); rd(10'h04);
    // R3: enabled receive with back-pressure
    cur_req = "R3";
    wr(10'h0C, EN_RX); rx(8'hA5, 1); idle(1);
    rx(8'h5A, 4); rd(10'h00);
    // R5: data read returns byte and clears receive-full
    cur_req = "R5";
    rd(10'h04); rd(10'h00); rx(8'hC3, 1); rd(10'h04);
    // R2: interrupt enables
    cur_req = "R2";
    wr(10'h0C, EN_RX | 32'h20); idle(2); rx(8'h11, 1); idle(2); rd(10'h04); idle(2);
    wr(10'h0C, 32'h80); idle(2); wr(10'h0C, 32'h40); idle(2); wr(10'h0C, 32'h0); idle(2);
    // R6: small status writes
    cur_req = "R6";
    wr(10'h00, 32'h0); rd(10'h00); wr(10'h00, 32'h3FF); rd(10'h00);
    wr(10'h00, 32'h015); rd(10'h00);
    // R7: large status writes AND in
    cur_req = "R7";
    wr(10'h00, 32'h3FF); wr(10'h00, 32'hFFFF_FF3F); rd(10'h00);
    wr(10'h00, 32'h0000_0400); rd(10'h00);
    // R8: transmit path
    cur_req = "R8";
    wr(10'h00, 32'h0); wr(10'h0C, 32'h40); idle(1);
    wr(10'h04, 32'h1234); idle(2); rd(10'h00);
    wr(10'h00, 32'h0); wr(10'h04, 32'hF000); rd(10'h00);
    wr(10'h04, 32'hEFFF); wr(10'h04, 32'hFFFF_FFFF); rd(10'h00);
    // R10: unmapped and misaligned
    cur_req = "R10";
    rd(10'h1C); rd(10'h3FC); wr(10'h20, 32'hFFFF_FFFF); wr(10'h3FC, 32'h1);
    wr(10'h0F, 32'h0000_2004); rd(10'h0D); rd(10'h0B);
    for (int a = 0; a < 7; a++) rd(10'(a * 4));
    // R11: back-to-back access, read shows pre-update value
    cur_req = "R11";
    @(negedge clk); bus_valid = 1; bus_we = 0; bus_addr = 10'h0C;
    @(negedge clk); bus_we = 1; bus_wdata = 32'h0000_55AA;
    @(negedge clk); bus_we = 0;
    @(negedge clk); bus_valid = 0;
    // R12: same-cycle ordering
    cur_req = "R12";
    wr(10'h0C, EN_RX | 32'hE0);
    @(negedge clk); bus_valid = 1; bus_we = 0; bus_addr = 10'h04; rx_valid = 1; rx_byte = 8'h77;
    @(negedge clk); bus_valid = 0; rx_valid = 0;
    @(negedge clk); bus_valid = 1; bus_we = 1; bus_addr = 10'h00; bus_wdata = 32'h0;
    rx_valid = 1; rx_byte = 8'h99;
    @(negedge clk); bus_valid = 0; bus_we = 0; rx_valid = 0;
    rd(10'h00); rd(10'h04);
    @(negedge clk); bus_valid = 1; bus_we = 1; bus_addr = 10'h00; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); bus_addr = 10'h04; bus_wdata = 32'h42;
    @(negedge clk); bus_valid = 0; bus_we = 0;
    rd(10'h00);
    // random mix against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      bus_valid = $urandom_range(0, 1);
      bus_we    = $urandom_range(0, 1);
      bus_addr  = ($urandom_range(0, 3) == 0) ? 10'($urandom) : 10'($urandom_range(0, 27));
      case ($urandom_range(0, 3))
        0: bus_wdata = $urandom_range(0, 32'h3FF);
        1: bus_wdata = $urandom_range(32'hEF00, 32'hF100);
        2: bus_wdata = EN_RX | 32'($urandom_range(0, 255));
        default: bus_wdata = $urandom;
      endcase
      rx_valid = $urandom_range(0, 1);
      rx_byte  = 8'($urandom);
    end
    @(negedge clk); bus_valid = 0; rx_valid = 0;
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(TCK * MAX_CYC);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog (%s) actual=running expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule